// File: doc/BRIEF.md
# Synthesizer Program Interface and VCO Band Search

This block is the digital control core of an integer-N frequency synthesizer. A host shifts 24-bit program words in over a three-wire serial port (clock, data, load enable). The two lowest bits of each word are an address. They route the rest of the word into the control latch, the reference-divider latch or the feedback (N) divider latch. Address 3 is reserved for test and is discarded.

The block enforces a start-up programming order. The reference latch must be written first, then the control latch, then the N latch. The N write that completes this order launches the first automatic VCO band search. After that, every N write launches a new search. An N write that arrives too early still updates the N latch. It also raises a sequence-error flag and launches no search. The flag stays set until an N write arrives after a correct order.

A search runs for exactly five band-select ticks. A band-select tick is one reference-divider tick out of every 1, 2, 4 or 8, as set by a two-bit field in the reference latch. While the search runs, the tune-switch output holds the loop filter off the tuning node. The first tick seeds a 3-bit trial code of 100. The next three ticks each settle one bit, most significant first, from a comparator that reports whether the tuning voltage is high. The fifth tick publishes the code and releases the switch. All inputs are sampled in the system clock domain.

Top module: `synth_ctl_core`

## Requirements
- R1: Serial data is shifted in MSB first, one bit per rising edge of `sclk`. On a rising edge of `sle`, the last 24 bits form a word. Word bits [1:0] select the target: 00 writes the control latch, 01 writes the reference latch, 10 writes the N latch. That latch takes word bits [23:2].
- R2: A word with address 11 changes none of the three latches.
- R3: Before the first accepted N write, an N write is accepted only if the reference latch has been written and a control write has followed it. Once one N write has been accepted, every later N write is accepted.
- R4: An N write that is not accepted still stores its data and sets `seq_err`. It starts no search. `seq_err` clears on the next accepted N write.
- R5: An accepted N write raises `busy` and `tune_hold`, and both stay high until the search ends.
- R6: A band-select tick occurs on every 2^S-th `ref_tick` of a search, where S is reference-latch word bits [23:22]. The prescaler restarts when a search starts.
- R7: A search ends on exactly its fifth band-select tick. At that point `busy` and `tune_hold` fall.
- R8: The published band code is {c2, c1, c0}, where c2, c1 and c0 are the `cmp_high` values sampled at band-select ticks 2, 3 and 4.
- R9: `band_code` keeps its previous value during a search and changes only on the fifth tick.
- R10: `vco_current` equals control-latch word bits [5:4].
- R11: After reset, all latches, `band_code`, `busy`, `tune_hold` and `seq_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock (sampled) |
| sdata | input | 1 | Serial data |
| sle | input | 1 | Load enable; rising edge transfers the word |
| ref_tick | input | 1 | One-cycle pulse from the reference divider |
| cmp_high | input | 1 | Tuning voltage comparator, 1 = high |
| ctl_word | output | 22 | Control latch contents |
| ref_word | output | 22 | Reference latch contents |
| ndiv_word | output | 22 | N latch contents |
| vco_current | output | 2 | VCO core current level |
| band_code | output | 3 | Selected VCO band |
| busy | output | 1 | Band search in progress |
| tune_hold | output | 1 | Loop filter disconnected from the tuning node |
| seq_err | output | 1 | Programming order violated |

## Verification
Assertions check on every cycle that a load-enable edge produces a word, that reserved writes leave the latches unchanged and that a rejected N write never coincides with a search start. They also check that `band_code` holds through a search and that every search closes after exactly five band-select ticks. Only the bench scenarios show the rules that depend on history and data. These are the reference-then-control order that arms the first search, the clearing of the error flag, the prescaler ratio taken from the reference latch, and the bit-by-bit result of the binary search for chosen comparator patterns.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int BAND_W = 3;
  localparam int PSC_W  = 2;

  typedef enum logic [1:0] {
    DST_CTL  = 2'b00,
    DST_REF  = 2'b01,
    DST_NDIV = 2'b10,
    DST_TEST = 2'b11
  } dst_e;
endpackage

// File: rtl/sctl_shift_in.sv
module sctl_shift_in #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sle,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  logic              sclk_d;
  logic              sle_d;
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      sle_d    <= 1'b0;
      sreg     <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      sclk_d   <= sclk;
      sle_d    <= sle;
      word_vld <= 1'b0;
      if (sclk && !sclk_d) sreg <= {sreg[WORD_W-2:0], sdata};
      if (sle && !sle_d) begin
        word_vld <= 1'b1;
        word     <= sreg;
      end
    end
  end

  // R1: every load-enable rising edge yields exactly one word strobe
  a_r1_load_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(sle) |=> word_vld);
  a_r1_strobe_single: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
endmodule

// File: rtl/sctl_latch_bank.sv
module sctl_latch_bank
  import synth_ctl_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic [PAY_W-1:0]  ctl_q,
  output logic [PAY_W-1:0]  ref_q,
  output logic [PAY_W-1:0]  ndiv_q,
  output logic              start_run,
  output logic              seq_err
);
  dst_e             dst;
  logic [PAY_W-1:0] pay;
  logic             ref_seen;
  logic             ctl_seen;
  logic             armed;

  assign dst = dst_e'(word[1:0]);
  assign pay = word[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      ref_q     <= '0;
      ndiv_q    <= '0;
      start_run <= 1'b0;
      seq_err   <= 1'b0;
      ref_seen  <= 1'b0;
      ctl_seen  <= 1'b0;
      armed     <= 1'b0;
    end else begin
      start_run <= 1'b0;
      if (word_vld) begin
        case (dst)
          DST_CTL: begin
            ctl_q <= pay;
            if (ref_seen) ctl_seen <= 1'b1;
          end
          DST_REF: begin
            ref_q    <= pay;
            ref_seen <= 1'b1;
          end
          DST_NDIV: begin
            ndiv_q <= pay;
            if (armed || (ref_seen && ctl_seen)) begin
              start_run <= 1'b1;
              armed     <= 1'b1;
              seq_err   <= 1'b0;
            end else begin
              seq_err <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: reserved address leaves every latch untouched
  a_r2_test_ignored: assert property (@(posedge clk) disable iff (rst)
    (word_vld && dst == DST_TEST) |=> ($stable(ctl_q) && $stable(ref_q) && $stable(ndiv_q)));
  // R1: N latch captures the payload of its word
  a_r1_ndiv_capture: assert property (@(posedge clk) disable iff (rst)
    (word_vld && dst == DST_NDIV) |=> ndiv_q == $past(pay));
  // R4: an error state never coexists with a launched search
  a_r4_err_no_start: assert property (@(posedge clk) disable iff (rst)
    !(seq_err && start_run));
  // R3: a search only launches from an N write
  a_r3_start_from_n: assert property (@(posedge clk) disable iff (rst)
    start_run |-> $past(word_vld && dst == DST_NDIV));
endmodule

// File: rtl/sctl_band_seq.sv
module sctl_band_seq #(
  parameter int BAND_W = 3,
  parameter int PSC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ref_tick,
  input  logic              cmp_high,
  input  logic [PSC_W-1:0]  psc_sel,
  output logic [BAND_W-1:0] band_code,
  output logic              busy,
  output logic              tune_hold
);
  localparam int RUN_TICKS = BAND_W + 2;
  localparam int IDX_W     = $clog2(RUN_TICKS + 1);
  localparam int PCNT_W    = (1 << PSC_W) - 1;

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] pmask;
  logic [IDX_W-1:0]  idx;
  logic [BAND_W-1:0] trial;
  logic              bs_tick;
  logic              bs_last;
  int                bpos;

  always_comb begin
    for (int i = 0; i < PCNT_W; i++) pmask[i] = (int'(psc_sel) > i);
  end

  assign bs_tick = busy && ref_tick && (pcnt == pmask);
  assign bs_last = bs_tick && (int'(idx) == RUN_TICKS - 1);
  assign bpos    = BAND_W - int'(idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt      <= '0;
      idx       <= '0;
      trial     <= '0;
      band_code <= '0;
      busy      <= 1'b0;
      tune_hold <= 1'b0;
    end else if (start) begin
      pcnt      <= '0;
      idx       <= '0;
      busy      <= 1'b1;
      tune_hold <= 1'b1;
    end else if (busy && ref_tick) begin
      if (pcnt == pmask) begin
        pcnt <= '0;
        idx  <= idx + 1'b1;
        if (idx == '0) begin
          trial <= BAND_W'(1) << (BAND_W - 1);
        end else if (int'(idx) <= BAND_W) begin
          for (int k = 0; k < BAND_W; k++) begin
            if (k == bpos) trial[k] <= cmp_high;
            else if (k == bpos - 1) trial[k] <= 1'b1;
          end
        end else begin
          band_code <= trial;
          busy      <= 1'b0;
          tune_hold <= 1'b0;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // checker-side tick counter for the run-length property
  logic [IDX_W-1:0] chk_ticks;
  always_ff @(posedge clk) begin
    if (rst || start) chk_ticks <= '0;
    else if (bs_tick) chk_ticks <= chk_ticks + 1'b1;
  end

  // R7: every search closes after exactly RUN_TICKS band-select ticks
  a_r7_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> int'(chk_ticks) == RUN_TICKS);
  // R9: published code is frozen until the final tick
  a_r9_band_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !bs_last) |=> $stable(band_code));
  // R5: a start request enters the search with the switch engaged
  a_r5_hold_on_start: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && tune_hold));
  // R8: first tick seeds the midpoint trial code
  a_r8_trial_seed: assert property (@(posedge clk) disable iff (rst)
    (bs_tick && idx == '0 && !start) |=> trial == (BAND_W'(1) << (BAND_W - 1)));
endmodule

// File: rtl/synth_ctl_core.sv
module synth_ctl_core
  import synth_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk,
  input  logic                     sdata,
  input  logic                     sle,
  input  logic                     ref_tick,
  input  logic                     cmp_high,
  output logic [WORD_W-ADDR_W-1:0] ctl_word,
  output logic [WORD_W-ADDR_W-1:0] ref_word,
  output logic [WORD_W-ADDR_W-1:0] ndiv_word,
  output logic [1:0]               vco_current,
  output logic [BAND_W-1:0]        band_code,
  output logic                     busy,
  output logic                     tune_hold,
  output logic                     seq_err
);
  localparam int PAY_W = WORD_W - ADDR_W;

  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              start_run;

  sctl_shift_in #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sle(sle),
    .word_vld(word_vld), .word(word)
  );

  sctl_latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word(word),
    .ctl_q(ctl_word), .ref_q(ref_word), .ndiv_q(ndiv_word),
    .start_run(start_run), .seq_err(seq_err)
  );

  sctl_band_seq #(.BAND_W(BAND_W), .PSC_W(PSC_W)) u_band (
    .clk(clk), .rst(rst), .start(start_run), .ref_tick(ref_tick),
    .cmp_high(cmp_high), .psc_sel(ref_word[PAY_W-1 -: PSC_W]),
    .band_code(band_code), .busy(busy), .tune_hold(tune_hold)
  );

  // R10: core current level taken from control word bits [5:4]
  assign vco_current = ctl_word[3:2];
endmodule

// File: tb/test_synth_ctl_core.sv
module test_synth_ctl_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic        ref_tick = 1'b0, cmp_high = 1'b0;
  logic [21:0] ctl_word, ref_word, ndiv_word;
  logic [1:0]  vco_current;
  logic [2:0]  band_code;
  logic        busy, tune_hold, seq_err;

  int checks = 0;
  int failures = 0;
  logic [21:0] e_ctl = '0, e_ref = '0, e_ndiv = '0;
  logic [2:0]  e_band = '0;

  always #5 clk = ~clk;

  synth_ctl_core i_synth_ctl_core (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sle(sle),
    .ref_tick(ref_tick), .cmp_high(cmp_high), .ctl_word(ctl_word),
    .ref_word(ref_word), .ndiv_word(ndiv_word), .vco_current(vco_current),
    .band_code(band_code), .busy(busy), .tune_hold(tune_hold), .seq_err(seq_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_latches(input string req);
    check(req, 32'(ctl_word), 32'(e_ctl));
    check(req, 32'(ref_word), 32'(e_ref));
    check(req, 32'(ndiv_word), 32'(e_ndiv));
    check("R10", 32'(vco_current), 32'(e_ctl[3:2]));
  endtask

  task automatic send_word(input logic [21:0] pay, input logic [1:0] addr);
    logic [23:0] w;
    w = {pay, addr};
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); sdata = w[i]; sclk = 1'b1;
      @(negedge clk);
      @(negedge clk); sclk = 1'b0;
      @(negedge clk);
    end
    @(negedge clk); sle = 1'b1;
    @(negedge clk);
    @(negedge clk); sle = 1'b0;
    repeat (4) @(negedge clk);
    case (addr)
      2'b00: e_ctl = pay;
      2'b01: e_ref = pay;
      2'b10: e_ndiv = pay;
      default: ;
    endcase
  endtask

  task automatic pulse_ref();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
    @(negedge clk);
  endtask

  // R6/R7/R8/R9: drive a full search for target code tgt
  task automatic run_search(input logic [2:0] tgt);
    int ratio;
    ratio = 1 << e_ref[21:20];
    for (int k = 1; k <= 5; k++) begin
      for (int j = 0; j < ratio; j++) begin
        if (j == ratio - 1) begin
          if (k == 2) cmp_high = tgt[2];
          else if (k == 3) cmp_high = tgt[1];
          else if (k == 4) cmp_high = tgt[0];
          else cmp_high = $urandom_range(0, 1);
        end
        if (k == 5 && j == ratio - 1 && ratio > 1)
          check("R6 prescaled tick not yet due", 32'(busy), 32'd1);
        pulse_ref();
      end
      if (k == 4) begin
        check("R9 code held mid-search", 32'(band_code), 32'(e_band));
        check("R5 busy during search", 32'(busy), 32'd1);
        check("R5 tune_hold during search", 32'(tune_hold), 32'd1);
      end
    end
    e_band = tgt;
    check("R7 busy cleared after fifth tick", 32'(busy), 32'd0);
    check("R7 tune_hold released", 32'(tune_hold), 32'd0);
    check("R8 band result", 32'(band_code), 32'(tgt));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [21:0] p;
    logic [1:0]  a;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check_latches("R11");
    check("R11 band", 32'(band_code), 32'd0);
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 hold", 32'(tune_hold), 32'd0);
    check("R11 err", 32'(seq_err), 32'd0);

    // R4: premature N write stores data but flags error
    send_word(22'h1234A, 2'b10);
    check_latches("R1 N stored");
    check("R4 error set", 32'(seq_err), 32'd1);
    check("R4 no search", 32'(busy), 32'd0);

    // R3: control before reference does not count
    send_word(22'h00030, 2'b00);
    send_word(22'h200000, 2'b01);   // prescale select 2 -> divide by 4
    send_word(22'h0ABCD, 2'b10);
    check_latches("R1 order writes");
    check("R3 still rejected", 32'(seq_err), 32'd1);
    check("R3 no search", 32'(busy), 32'd0);

    // R2: reserved writes do nothing
    send_word(22'h3FFFFF, 2'b11);
    check_latches("R2");

    send_word(22'h00024, 2'b00);
    check_latches("R10 control");
    check("R3 error persists before N", 32'(seq_err), 32'd1);

    send_word(22'h00777, 2'b10);
    check("R4 error cleared", 32'(seq_err), 32'd0);
    check("R5 busy", 32'(busy), 32'd1);
    check("R5 tune_hold", 32'(tune_hold), 32'd1);
    run_search(3'b101);

    send_word(22'h300000, 2'b01);   // divide by 8
    send_word(22'h00001, 2'b10);
    run_search(3'b000);
    send_word(22'h000000, 2'b01);   // divide by 1
    send_word(22'h00002, 2'b10);
    run_search(3'b111);

    for (int n = 0; n < 30; n++) begin
      p = 22'($urandom);
      a = 2'($urandom_range(0, 3));
      send_word(p, a);
      check_latches(a == 2'b11 ? "R2 random" : "R1 random");
      if (a == 2'b10) begin
        check("R3 armed accepts", 32'(busy), 32'd1);
        run_search(3'($urandom_range(0, 7)));
      end else begin
        check("R9 idle code", 32'(band_code), 32'(e_band));
      end
    end
    check("R4 stays clear", 32'(seq_err), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule